// File: doc/BRIEF.md
# Port Input Change Watcher with Latching Interrupt

This block watches a byte of open-drain port pins for any level change since the last serial-bus access to the device. The pins pass through a synchronizer. Each synchronized level is then compared against a baseline snapshot. When a watched bit differs from its baseline, a per-bit change flag is latched and an active-low interrupt is pulled down. Both the flags and the interrupt stay latched until the bus engine reports the acknowledge of the next access to this device.

At that acknowledge, three things happen on the same clock edge. The snapshot is retaken from the present levels. The flags are copied into a read holding register. The live flags and the interrupt are cleared. The bus engine then reads two bytes through a registered readback path: first the port levels, then the held flags.

Only bits marked as inputs are watched. A bit that was just switched to input mode by the device's own write is held out of the comparison until the synchronizer has settled. Its snapshot keeps following the pin during that time, so changes caused by the device itself never raise the interrupt.

Top module: `pinwatch_top`

## Requirements
- R1: When `rst` is high at a clock edge, that edge clears `flags`, `rd_data`, `port_lvl` and the snapshot, and drives `irq_n` to 1. If the pins are steady after `rst` falls, no flag is set.
- R2: A level change on a watched bit is sampled into the synchronizer at edge k. The flag bit for that pin reads 1 after edge k+2, and `irq_n` reads 0 after that same edge.
- R3: A flag bit stays 1 after its pin returns to the old level. `irq_n` stays 0 until an accepted acknowledge.
- R4: An accepted acknowledge is `acc_ack`=1 with `bus_rst`=0 at an edge. That edge clears all flags, sets `irq_n` to 1 and reloads the snapshot from the current synchronized levels. A level present at that edge later causes no flag.
- R5: At an accepted acknowledge, the holding register takes the old flags ORed with any flags set at that same edge. `rd_data` is registered. After each edge it shows the holding register when `rd_sel` was 1 at that edge, and `port_lvl` when `rd_sel` was 0.
- R6: A bit whose `in_mode` is 0 (1 means input) never sets its flag. Its snapshot follows its synchronized level.
- R7: A bit is watched at an edge only if its `in_mode` bit was 1 at that edge and at the three edges before it since reset (SYNC_STAGES+1). Pin changes inside that window set no flag.
- R8: While `bus_rst` is 1, `acc_ack` is ignored. Flags, `irq_n` and the snapshot are not changed by `bus_rst`.
- R9: `port_lvl` equals `pins_in` delayed by two clock edges (SYNC_STAGES).
- R10: Several watched bits changing together each set their own flag bit. Bits that did not change keep their flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pins_in | input | WIDTH | Asynchronous port pin levels |
| in_mode | input | WIDTH | Per-bit mode, 1 = input (watched) |
| acc_ack | input | 1 | One-cycle pulse at the acknowledge of any access to this device |
| bus_rst | input | 1 | Bus reset; voids the access in progress |
| rd_sel | input | 1 | Readback select: 0 = port levels, 1 = held flags |
| port_lvl | output | WIDTH | Synchronized port levels |
| flags | output | WIDTH | Live latched change flags |
| rd_data | output | WIDTH | Registered readback byte |
| irq_n | output | 1 | Active-low latching interrupt |

## Verification
The checker asserts on every cycle that:
- reset and accepted acknowledges clear the flags and raise the interrupt;
- flags never drop except at an accepted acknowledge;
- an output-mode bit never raises a new flag;
- any set flag holds the interrupt low.

Only the bench scenarios can show the remaining behaviour, using a behavioural model compared every clock:
- the exact two-edge latency of a pin change;
- the settle window after a bit turns to input;
- the capture of a flag set on the very edge of the acknowledge;
- the ordering of the two readback bytes.

// File: rtl/pinwatch_pkg.sv
package pinwatch_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned DEF_SYNC  = 2;

  typedef enum logic {
    RD_PORT  = 1'b0,
    RD_FLAGS = 1'b1
  } rd_pick_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mode_settle.sv
module mode_settle #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mode,
  output logic [W-1:0] watch
);
  logic [W-1:0] hist [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) hist[0] <= '0;
    else     hist[0] <= mode;
  end

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_hist
      always_ff @(posedge clk) begin
        if (rst) hist[i] <= '0;
        else     hist[i] <= hist[i-1];
      end
    end
  endgenerate

  always_comb begin
    watch = mode;
    for (int i = 0; i < DEPTH; i++) watch = watch & hist[i];
  end
endmodule

// File: rtl/change_tracker.sv
module change_tracker #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] watch,
  input  logic         take,
  output logic [W-1:0] flags_q,
  output logic [W-1:0] hold_q,
  output logic         irq_n_q
);
  logic [W-1:0] snap_q;
  logic [W-1:0] hit;
  logic [W-1:0] flags_nx;

  always_comb begin
    hit      = watch & (lvl ^ snap_q);
    flags_nx = flags_q | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      flags_q <= '0;
      hold_q  <= '0;
      irq_n_q <= 1'b1;
    end else if (take) begin
      snap_q  <= lvl;
      hold_q  <= flags_nx;
      flags_q <= '0;
      irq_n_q <= 1'b1;
    end else begin
      snap_q  <= (snap_q & watch) | (lvl & ~watch);
      flags_q <= flags_nx;
      irq_n_q <= ~(|flags_nx);
    end
  end
endmodule

// File: rtl/pinwatch_top.sv
module pinwatch_top
  import pinwatch_pkg::*;
#(
  parameter int unsigned WIDTH       = DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_in,
  input  logic [WIDTH-1:0] in_mode,
  input  logic             acc_ack,
  input  logic             bus_rst,
  input  logic             rd_sel,
  output logic [WIDTH-1:0] port_lvl,
  output logic [WIDTH-1:0] flags,
  output logic [WIDTH-1:0] rd_data,
  output logic             irq_n
);
  localparam int unsigned SETTLE = SYNC_STAGES + 1;

  logic [WIDTH-1:0] lvl_s;
  logic [WIDTH-1:0] watch;
  logic [WIDTH-1:0] hold;
  logic             take;
  rd_pick_e         pick;

  assign take = acc_ack & ~bus_rst;
  assign pick = rd_pick_e'(rd_sel);

  pin_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins_in), .q(lvl_s)
  );

  mode_settle #(.W(WIDTH), .DEPTH(SETTLE)) u_settle (
    .clk(clk), .rst(rst), .mode(in_mode), .watch(watch)
  );

  change_tracker #(.W(WIDTH)) u_track (
    .clk(clk), .rst(rst), .lvl(lvl_s), .watch(watch), .take(take),
    .flags_q(flags), .hold_q(hold), .irq_n_q(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= (pick == RD_FLAGS) ? hold : lvl_s;
  end

  assign port_lvl = lvl_s;
endmodule

// File: rtl/pinwatch_chk.sv
module pinwatch_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         acc_ack,
  input logic         bus_rst,
  input logic [W-1:0] in_mode,
  input logic [W-1:0] flags,
  input logic         irq_n
);
  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (flags == '0) && irq_n);

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (acc_ack && !bus_rst) |=> (flags == '0) && irq_n);

  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !(acc_ack && !bus_rst) |=> ((flags & $past(flags)) == $past(flags)));

  a_r8_busrst_keeps: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> (($past(flags) & ~flags) == '0));

  a_r6_output_no_flag: assert property (@(posedge clk) disable iff (rst)
    (flags & ~$past(flags) & ~$past(in_mode)) == '0);

  a_r2_flag_means_irq: assert property (@(posedge clk) disable iff (rst)
    (flags != '0) |-> !irq_n);
endmodule

bind pinwatch_top pinwatch_chk #(.W(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .acc_ack(acc_ack), .bus_rst(bus_rst),
  .in_mode(in_mode), .flags(flags), .irq_n(irq_n)
);

// File: tb/sim_pinwatch_top.sv
`timescale 1ns/1ps
module sim_pinwatch_top;
  localparam int W = 8;
  localparam int L = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] pins_in = 8'hFF;
  logic [W-1:0] in_mode = 8'hFF;
  logic acc_ack = 1'b0, bus_rst = 1'b0, rd_sel = 1'b0;
  logic [W-1:0] port_lvl, flags, rd_data;
  logic irq_n;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pinwatch_top u0 (
    .clk(clk), .rst(rst), .pins_in(pins_in), .in_mode(in_mode),
    .acc_ack(acc_ack), .bus_rst(bus_rst), .rd_sel(rd_sel),
    .port_lvl(port_lvl), .flags(flags), .rd_data(rd_data), .irq_n(irq_n)
  );

  // behavioural reference
  logic [W-1:0] m_p1 = '0, m_p2 = '0, m_snap = '0, m_flags = '0, m_hold = '0, m_rd = '0;
  logic m_irq_n = 1'b1;
  logic [W-1:0] mh[$] = '{8'h00, 8'h00, 8'h00};

  always @(posedge clk) begin
    logic [W-1:0] eff, newf;
    if (rst) begin
      m_p1 = '0; m_p2 = '0; m_snap = '0; m_flags = '0; m_hold = '0; m_rd = '0;
      m_irq_n = 1'b1;
      mh = '{8'h00, 8'h00, 8'h00};
    end else begin
      eff = in_mode;
      foreach (mh[i]) eff = eff & mh[i];
      newf = m_flags | (eff & (m_p2 ^ m_snap));
      m_rd = rd_sel ? m_hold : m_p2;
      if (acc_ack && !bus_rst) begin
        m_hold = newf; m_flags = '0; m_snap = m_p2; m_irq_n = 1'b1;
      end else begin
        m_flags = newf;
        m_snap = (m_snap & eff) | (m_p2 & ~eff);
        m_irq_n = (newf == '0);
      end
      mh.push_front(in_mode);
      void'(mh.pop_back());
      m_p2 = m_p1; m_p1 = pins_in;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2/R3/R4 model flags", flags, m_flags);
      chk("R2/R4 model irq_n", {7'b0, irq_n}, {7'b0, m_irq_n});
      chk("R9 model port_lvl", port_lvl, m_p2);
      chk("R5 model rd_data", rd_data, m_rd);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      finish_run();
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 flags after reset", flags, 8'h00);
    chk("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
    chk("R1 rd_data after reset", rd_data, 8'h00);
    step(6);
    chk("R1 no spurious flag", flags, 8'h00);

    // R2 and R9 latency
    pins_in = 8'hFE;
    step(2);
    chk("R9 port_lvl after two edges", port_lvl, 8'hFE);
    chk("R2 flag not yet", flags, 8'h00);
    step(1);
    chk("R2 flag set", flags, 8'h01);
    chk("R2 irq low", {7'b0, irq_n}, 8'h00);

    // R3 sticky
    pins_in = 8'hFF;
    step(4);
    chk("R3 flag sticky", flags, 8'h01);
    chk("R3 irq still low", {7'b0, irq_n}, 8'h00);

    // R4 acknowledge, R5 readback
    rd_sel = 1'b1; acc_ack = 1'b1;
    step(1);
    acc_ack = 1'b0;
    chk("R4 flags cleared", flags, 8'h00);
    chk("R4 irq released", {7'b0, irq_n}, 8'h01);
    step(1);
    chk("R5 held flags read", rd_data, 8'h01);
    rd_sel = 1'b0;
    step(1);
    chk("R5 port byte read", rd_data, 8'hFF);
    step(4);
    chk("R4 baseline reloaded", flags, 8'h00);

    // R10 multiple bits
    pins_in = 8'hD7;
    step(4);
    chk("R10 two flags", flags, 8'h28);

    // R8 bus reset voids ack
    bus_rst = 1'b1; acc_ack = 1'b1;
    step(1);
    acc_ack = 1'b0;
    step(1);
    bus_rst = 1'b0;
    chk("R8 flags kept", flags, 8'h28);
    chk("R8 irq kept", {7'b0, irq_n}, 8'h00);

    // R6 output-mode bit ignored
    acc_ack = 1'b1;
    step(1);
    acc_ack = 1'b0;
    in_mode = 8'h0F;
    step(1);
    pins_in = 8'h57;
    step(5);
    chk("R6 output bit no flag", flags, 8'h00);
    chk("R6 irq high", {7'b0, irq_n}, 8'h01);

    // R7 settle window
    in_mode = 8'hFF; pins_in = 8'hD7;
    step(6);
    chk("R7 settle no flag", flags, 8'h00);
    pins_in = 8'h57;
    step(4);
    chk("R7 watched after settle", flags, 8'h80);

    // R5 capture of a flag set on the acknowledge edge
    rd_sel = 1'b1;
    pins_in = 8'h55;
    step(2);
    acc_ack = 1'b1;
    step(1);
    acc_ack = 1'b0;
    chk("R5 flags cleared at capture", flags, 8'h00);
    step(1);
    chk("R5 same-edge flag captured", rd_data, 8'h82);
    step(4);
    chk("R4 no late flag", flags, 8'h00);
    rd_sel = 1'b0;
    step(2);
    chk("R5 port byte", rd_data, 8'h55);

    finish_run();
  end
endmodule